// File: doc/BRIEF.md
# Paced Parallel Pin Port

This block turns an eight-line pin group into a general-purpose parallel port. Bytes arrive on a valid/ready stream from a host-side buffer and are driven onto the pins one at a time. The rate is set by an external pacing tick, which is the same tick that divides the serial baud rate. A per-bit direction mask selects which lines the block drives. The remaining lines are released, and their output enable is low.

Pin states return to the host as a second byte stream. In free-running mode the pins are sampled on every pacing tick whenever the return slot is empty, so reads are independent of writes. In lockstep mode a sample is taken only when a byte is written. That sample is captured on the same edge that drives the new byte, so it shows the pins as they were just before the output changed. Each write stimulus therefore has exactly one response. Active-low write and read strobes mark each drive and each capture, so that external logic can clock on port accesses.

Top module: `pio_bitbang`

## Requirements
- R1: After reset, pin_out is 0, wr_n and rd_n are 1, rd_valid is 0, and wr_ready is 0 while pace_tick is 0.
- R2: wr_ready is 1 only in a cycle where pace_tick is 1, so at most one byte is taken per tick.
- R3: A byte taken at a clock edge appears on the driven bits of pin_out just after that edge. It is held there until the next byte is taken.
- R4: pin_oe bit i equals dir_mask bit i. pin_out bit i is 0 wherever dir_mask bit i is 0.
- R5: wr_n goes low only on the edge where a byte is taken. It returns high on the next edge that has pace_tick 1 and no new byte, so it stays low for one pacing interval.
- R6: A tick that finds the input stream empty takes no byte, leaves pin_out unchanged and produces no wr_n low pulse.
- R7: With sync_mode 0 (free-running), every edge with pace_tick 1 and rd_valid 0 loads pin_in into rd_data and sets rd_valid, whether or not a byte is written.
- R8: With sync_mode 1 (lockstep), a sample is captured only on the edge where a byte is taken. It holds pin_in as it stood before that byte reached the pins, and ticks without a write capture nothing.
- R9: rd_n goes low on each capture edge. It returns high on the next tick that captures nothing.
- R10: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data stays stable. With sync_mode 1, wr_ready is 0 while rd_valid is 1.
- R11: With sync_mode 0, a full return slot does not hold back writes: wr_ready follows pace_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 0 free-running sampling, 1 lockstep sampling |
| pace_tick | input | 1 | One-cycle pacing pulse from the rate timer |
| dir_mask | input | 8 | 1 = line driven, 0 = line released |
| wr_valid | input | 1 | Output byte available |
| wr_data | input | 8 | Output byte |
| wr_ready | output | 1 | Byte taken this cycle when wr_valid is 1 |
| rd_valid | output | 1 | Sample available |
| rd_data | output | 8 | Sampled pin states |
| rd_ready | input | 1 | Consumer takes the sample |
| pin_in | input | 8 | Pin states as seen at the pads |
| pin_out | output | 8 | Value driven on the lines |
| pin_oe | output | 8 | Per-line output enable |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe |

## Verification
The properties assume that pace_tick is a single-cycle pulse from a timer. They also assume that sync_mode is changed only while no byte is offered. Properties that compare pin_out across cycles assume dir_mask is stable over those cycles. The bench drives every input at the falling edge and holds each one for a whole cycle. It changes mode and mask only between scenarios, while the streams are idle. It models the pads as a loopback: driven lines read back pin_out, and released lines read a bench-chosen external value.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic {
        MODE_FREE     = 1'b0,
        MODE_LOCKSTEP = 1'b1
    } pio_mode_e;

    function automatic pio_mode_e to_mode(input logic sel);
        return sel ? MODE_LOCKSTEP : MODE_FREE;
    endfunction

endpackage

// File: rtl/pio_admit.sv
module pio_admit (
    input  logic               tick,
    input  pio_pkg::pio_mode_e mode,
    input  logic               slot_free,
    input  logic               wr_valid,
    output logic               wr_ready,
    output logic               accept
);
    import pio_pkg::*;

    logic room_ok;

    always_comb begin
        // Lockstep mode needs a free return slot for the paired sample.
        room_ok  = (mode == MODE_FREE) || slot_free;
        wr_ready = tick && room_ok;
        accept   = wr_ready && wr_valid;
    end

endmodule

// File: rtl/pio_drive_stage.sv
module pio_drive_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         accept,
    input  logic [W-1:0] data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic         wr_n
);

    typedef struct packed {
        logic [W-1:0] level;
        logic         strobe_n;
    } drive_t;

    drive_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.level    = data;
            st_d.strobe_n = 1'b0;
        end else if (tick) begin
            st_d.strobe_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{level: '0, strobe_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        assign pin_oe[i]  = mask[i];
        assign pin_out[i] = mask[i] ? st_q.level[i] : 1'b0;
    end

    assign wr_n = st_q.strobe_n;

endmodule

// File: rtl/pio_sample_stage.sv
module pio_sample_stage #(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  pio_pkg::pio_mode_e mode,
    input  logic               accept,
    input  logic [W-1:0]       pin_in,
    input  logic               rd_ready,
    output logic               rd_valid,
    output logic [W-1:0]       rd_data,
    output logic               rd_n,
    output logic               slot_free
);
    import pio_pkg::*;

    typedef struct packed {
        logic [W-1:0] sample;
        logic         full;
        logic         strobe_n;
    } samp_t;

    samp_t st_d, st_q;
    logic  capture;

    always_comb begin
        if (mode == MODE_LOCKSTEP) begin
            capture = accept;
        end else begin
            capture = tick && !st_q.full;
        end

        st_d = st_q;
        if (st_q.full && rd_ready) begin
            st_d.full = 1'b0;
        end
        if (capture) begin
            st_d.sample   = pin_in;
            st_d.full     = 1'b1;
            st_d.strobe_n = 1'b0;
        end else if (tick) begin
            st_d.strobe_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sample: '0, full: 1'b0, strobe_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid  = st_q.full;
    assign rd_data   = st_q.sample;
    assign rd_n      = st_q.strobe_n;
    assign slot_free = !st_q.full;

endmodule

// File: rtl/pio_bitbang.sv
module pio_bitbang #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_mode,
    input  logic         pace_tick,
    input  logic [W-1:0] dir_mask,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    output logic         wr_ready,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    input  logic         rd_ready,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic         wr_n,
    output logic         rd_n
);
    import pio_pkg::*;

    pio_mode_e mode;
    logic      accept;
    logic      slot_free;

    assign mode = to_mode(sync_mode);

    pio_admit u_admit (
        .tick      (pace_tick),
        .mode      (mode),
        .slot_free (slot_free),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .accept    (accept)
    );

    pio_drive_stage #(.W(W)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (pace_tick),
        .accept  (accept),
        .data    (wr_data),
        .mask    (dir_mask),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .wr_n    (wr_n)
    );

    pio_sample_stage #(.W(W)) u_sample (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (pace_tick),
        .mode      (mode),
        .accept    (accept),
        .pin_in    (pin_in),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_n      (rd_n),
        .slot_free (slot_free)
    );

endmodule

// File: rtl/pio_bitbang_chk.sv
module pio_bitbang_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sync_mode,
    input logic         pace_tick,
    input logic [W-1:0] dir_mask,
    input logic         wr_valid,
    input logic [W-1:0] wr_data,
    input logic         wr_ready,
    input logic         rd_valid,
    input logic [W-1:0] rd_data,
    input logic         rd_ready,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic         wr_n,
    input logic         rd_n
);
    logic took;
    assign took = wr_valid && wr_ready;

    assert_ready_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> pace_tick);

    assert_pins_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (pin_out == ($past(wr_data) & dir_mask)));

    assert_released_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    assert_wr_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(took));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !took |=> (!$stable(dir_mask) || $stable(pin_out)));

    assert_lockstep_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && $rose(rd_valid)) |-> ($past(took) && $past(sync_mode)));

    assert_rd_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> !rd_n);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && rd_valid) |-> !wr_ready);

    assert_free_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && pace_tick) |-> wr_ready);

    logic unused_ok;
    assign unused_ok = ^{pin_in, rd_ready};

endmodule

bind pio_bitbang pio_bitbang_chk #(.W(W)) u_chk (.*);

// File: tb/test_pio_bitbang.sv
module test_pio_bitbang;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_mode;
    logic       pace_tick;
    logic [7:0] dir_mask;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic       wr_ready;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_ready;
    logic [7:0] pin_in;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       wr_n;
    logic       rd_n;
    logic [7:0] ext_pins;

    int n_cmp = 0;
    int n_bad = 0;
    logic ready_seen;

    always #5 clk = ~clk;

    // pad loopback: driven lines read back, released lines read the outside
    assign pin_in = (pin_out & pin_oe) | (ext_pins & ~pin_oe);

    pio_bitbang i_pio_bitbang (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .pace_tick(pace_tick),
        .dir_mask(dir_mask), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_ready(rd_ready), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .wr_n(wr_n), .rd_n(rd_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: drive at falling edge, note wr_ready, settle after rising edge
    task automatic step(input logic t, input logic v, input logic [7:0] d, input logic rr);
        @(negedge clk);
        pace_tick = t;
        wr_valid  = v;
        wr_data   = d;
        rd_ready  = rr;
        #1;
        ready_seen = wr_ready;
        @(posedge clk);
        #1;
        pace_tick = 1'b0;
        wr_valid  = 1'b0;
        rd_ready  = 1'b0;
    endtask

    task automatic drain();
        step(1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 wr_n", wr_n, 1'b1);
        chk("R1 rd_n", rd_n, 1'b1);
        chk("R1 rd_valid", rd_valid, 1'b0);
        chk("R1 wr_ready", wr_ready, 1'b0);
        chk("R4 oe", pin_oe, 8'hFF);
    endtask

    task automatic t_free_run();
        sync_mode = 1'b0;
        step(1'b0, 1'b1, 8'hA5, 1'b0);
        chk("R2 no ready without tick", ready_seen, 1'b0);
        chk("R2 pins unchanged", pin_out, 8'h00);
        step(1'b1, 1'b1, 8'hA5, 1'b0);
        chk("R2 ready on tick", ready_seen, 1'b1);
        chk("R3 pins driven", pin_out, 8'hA5);
        chk("R5 wr_n low", wr_n, 1'b0);
        chk("R7 sample old pins", rd_data, 8'h00);
        chk("R7 rd_valid", rd_valid, 1'b1);
        chk("R9 rd_n low", rd_n, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R5 wr_n low for interval", wr_n, 1'b0);
        chk("R3 hold", pin_out, 8'hA5);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R5 wr_n released", wr_n, 1'b1);
        chk("R6 pins hold on empty", pin_out, 8'hA5);
        chk("R9 rd_n released", rd_n, 1'b1);
        chk("R10 rd_valid held", rd_valid, 1'b1);
        chk("R10 rd_data held", rd_data, 8'h00);
        drain();
        chk("R10 drained", rd_valid, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R7 tick capture", rd_data, 8'hA5);
        chk("R7 valid", rd_valid, 1'b1);
        chk("R6 no wr pulse", wr_n, 1'b1);
        step(1'b1, 1'b1, 8'h5A, 1'b0);
        chk("R11 ready with full slot", ready_seen, 1'b1);
        chk("R11 pins", pin_out, 8'h5A);
        chk("R10 data kept", rd_data, 8'hA5);
        drain();
    endtask

    task automatic t_mask();
        logic [7:0] exp_in;
        dir_mask = 8'h0F;
        ext_pins = 8'hC0;
        #1;
        chk("R4 oe follows mask", pin_oe, 8'h0F);
        chk("R4 released bits low", pin_out, 8'h0A);
        exp_in = (8'h5A & 8'h0F) | (8'hC0 & 8'hF0);
        step(1'b1, 1'b1, 8'h3C, 1'b0);
        chk("R4 masked drive", pin_out, 8'h0C);
        chk("R7 mixed sample", rd_data, exp_in);
        drain();
        dir_mask = 8'hFF;
        step(1'b1, 1'b0, 8'h00, 1'b1);
        chk("R3 full level after unmask", pin_out, 8'h3C);
        drain();
    endtask

    task automatic t_lockstep();
        sync_mode = 1'b1;
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R8 no capture without write", rd_valid, 1'b0);
        step(1'b1, 1'b1, 8'h11, 1'b0);
        chk("R8 sample before change", rd_data, 8'h3C);
        chk("R8 valid", rd_valid, 1'b1);
        chk("R3 new drive", pin_out, 8'h11);
        chk("R9 rd_n with write", rd_n, 1'b0);
        chk("R5 wr_n with write", wr_n, 1'b0);
        step(1'b1, 1'b1, 8'h22, 1'b0);
        chk("R10 backpressure", ready_seen, 1'b0);
        chk("R10 pins held", pin_out, 8'h11);
        chk("R10 data held", rd_data, 8'h3C);
        drain();
        step(1'b1, 1'b1, 8'h22, 1'b0);
        chk("R8 paired sample", rd_data, 8'h11);
        chk("R3 pins", pin_out, 8'h22);
        drain();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        sync_mode = 1'b0;
        pace_tick = 1'b0;
        dir_mask  = 8'hFF;
        wr_valid  = 1'b0;
        wr_data   = 8'h00;
        rd_ready  = 1'b0;
        ext_pins  = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_free_run();
        t_mask();
        t_lockstep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule